// File: doc/BRIEF.md
# USB Host OUT Record Sequencer

This block sends a record of any length to one USB endpoint as a series of OUT packets. Each packet carries at most a parameter-set number of bytes, 64 by default. It reads the record byte by byte from a source memory and fills a two-bank transmit buffer through a byte-write strobe. For each packet it then commits the length through a byte-count strobe, clears the transfer-done flag and launches an OUT transfer.

While one bank is on the bus, the sequencer fills the other bank. Loading the next packet comes before handling the completion of the current one, so both banks stay in use. The sequencer keeps a length and a first byte for the bank now being sent ("current") and for the bank that is loaded and waiting ("pending"). When the device answers NAK, it resends the current packet. To do this it flips the banks with a zero byte count, rewrites the saved first byte, rewrites the saved length, clears the flag and launches again.

The operation ends with a one-cycle done pulse and a 4-bit result. The result is 0 on success, 4 when the NAK limit is reached, or any other handshake code passed through unchanged.

Top module: `usb_out_seq`

## Requirements
- R1: A record of N bytes is read from source addresses 0 to N-1 in order. It is written to the buffer as packets of min(64, bytes left) bytes, one byte per fifo write strobe.
- R2: After the first packet is loaded, the sequencer issues three strobes in order. The first writes that packet's length to the byte count. The second is a done-flag clear. The third is a launch whose code is 0x10 OR the 4-bit endpoint number.
- R3: After a launch, while bytes remain and a bank is free, the next packet is loaded before any completion is handled. At most two packets are loaded and unacknowledged at any time.
- R4: When a completion with result 4 (NAK) arrives and the limit is not reached, the sequencer retries in a fixed order. It writes byte count 0, writes the current packet's first byte, writes the current length, clears the done flag and launches again.
- R5: A NAK is counted. When the count of consecutive NAKs equals the NAK limit, the sequencer ends with result 4 and issues no further strobes.
- R6: A completion with result 0 (ACK) resets the NAK count. If a pending packet exists, it becomes current, and the sequencer writes its length, clears the done flag and launches it.
- R7: A completion with any result other than 0 or 4 ends the operation at once, returning that code.
- R8: When every byte is loaded and both banks have been acknowledged, done pulses for exactly one cycle with result 0.
- R9: A start with total length 0 raises done with result 0 on the next cycle and issues no buffer strobes.
- R10: A start pulse while busy is ignored. The running operation continues unchanged and produces a single done pulse.
- R11: A completion that arrives while the sequencer is still loading is held and acted on later. It is not lost.
- R12: After reset the block is idle: busy and done are low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| ep_i | input | 4 | Endpoint number |
| total_len_i | input | CNT_W | Record length in bytes |
| nak_limit_i | input | NAK_W | Consecutive NAKs that end the operation |
| src_addr_o | output | CNT_W | Source memory byte address |
| src_data_i | input | 8 | Source memory data at src_addr_o |
| fifo_wr_o | output | 1 | Buffer byte write strobe |
| fifo_data_o | output | 8 | Buffer byte |
| bc_wr_o | output | 1 | Byte-count write strobe (also flips banks) |
| bc_data_o | output | 8 | Byte count |
| irq_clr_o | output | 1 | Transfer-done flag clear strobe |
| launch_o | output | 1 | OUT transfer launch strobe |
| launch_code_o | output | 8 | Token code (upper nibble 1) with endpoint |
| xfer_done_i | input | 1 | Transfer completion pulse |
| xfer_result_i | input | 4 | Handshake result with the completion |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 4 | Final result code, held until next start |

## Verification
Bad current/pending bookkeeping shows up at the bank-flip strobe after the next ACK or NAK. The sequencer would then write the wrong length or the wrong first byte, or launch a packet that was already sent. A wrong NAK count shows up as an early or missing result 4. A lost completion shows up as a stall that the per-case timeout catches. The bench compares every strobe, on the clock it occurs, against a stream computed from the result script, so an error appears at the first strobe it affects.

// File: rtl/usb_out_seq_pkg.sv
package usb_out_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PLAN,
        ST_LOAD,
        ST_KICK_BC,
        ST_KICK_GO,
        ST_WAIT,
        ST_RETRY_ZERO,
        ST_RETRY_FB,
        ST_DONE
    } seq_state_e;

    localparam logic [3:0] HS_ACK    = 4'h0;
    localparam logic [3:0] HS_NAK    = 4'h4;
    localparam logic [3:0] TOKEN_OUT = 4'h1;

endpackage

// File: rtl/uos_done_latch.sv
module uos_done_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic [3:0] res_i,
    input  logic       clr_i,
    output logic       pend_o,
    output logic [3:0] res_o
);
    typedef struct packed {
        logic       pend;
        logic [3:0] res;
    } latch_t;

    latch_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (clr_i) begin
            l_d.pend = 1'b0;
        end else if (set_i) begin
            l_d.pend = 1'b1;
            l_d.res  = res_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign pend_o = l_q.pend;
    assign res_o  = l_q.res;

    // R11: a held completion stays until it is consumed or cleared
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.pend && !clr_i) |=> l_q.pend);

endmodule

// File: rtl/uos_bank_track.sv
module uos_bank_track #(
    parameter int BC_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            load_i,
    input  logic [BC_W-1:0] load_bc_i,
    input  logic [7:0]      load_fb_i,
    input  logic            ack_i,
    output logic [1:0]      avail_o,
    output logic [BC_W-1:0] cur_bc_o,
    output logic [7:0]      cur_fb_o
);
    typedef struct packed {
        logic [1:0]      avail;
        logic [BC_W-1:0] cur_bc;
        logic [7:0]      cur_fb;
        logic [BC_W-1:0] pend_bc;
        logic [7:0]      pend_fb;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr_i) begin
            b_d       = '0;
            b_d.avail = 2'd2;
        end else if (load_i) begin
            b_d.avail = b_q.avail - 2'd1;
            if (b_q.avail == 2'd2) begin
                b_d.cur_bc = load_bc_i;
                b_d.cur_fb = load_fb_i;
            end else begin
                b_d.pend_bc = load_bc_i;
                b_d.pend_fb = load_fb_i;
            end
        end else if (ack_i) begin
            b_d.avail = b_q.avail + 2'd1;
            if (b_q.avail == 2'd0) begin
                b_d.cur_bc = b_q.pend_bc;
                b_d.cur_fb = b_q.pend_fb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q       <= '0;
            b_q.avail <= 2'd2;
        end else begin
            b_q <= b_d;
        end
    end

    assign avail_o  = b_q.avail;
    assign cur_bc_o = b_q.cur_bc;
    assign cur_fb_o = b_q.cur_fb;

    // R3: never load into a full pair, never acknowledge an empty pair
    a_r3_no_overload: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (b_q.avail != 2'd0));
    a_r3_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> (b_q.avail != 2'd2));

endmodule

// File: rtl/uos_nak_guard.sv
module uos_nak_guard #(
    parameter int NAK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ack_i,
    input  logic             nak_i,
    input  logic [NAK_W-1:0] limit_i,
    output logic             hit_o
);
    logic [NAK_W-1:0] cnt_d, cnt_q;
    logic [NAK_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + NAK_W'(1);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || ack_i) cnt_d = '0;
        else if (nak_i)     cnt_d = cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = nak_i && (cnt_inc == limit_i);

    // R6: an ACK leaves the consecutive-NAK count at zero
    a_r6_ack_resets: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (cnt_q == '0));

endmodule

// File: rtl/usb_out_seq.sv
module usb_out_seq
    import usb_out_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NAK_W   = 16,
    parameter int PKT_MAX = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       ep_i,
    input  logic [CNT_W-1:0] total_len_i,
    input  logic [NAK_W-1:0] nak_limit_i,
    output logic [CNT_W-1:0] src_addr_o,
    input  logic [7:0]       src_data_i,
    output logic             fifo_wr_o,
    output logic [7:0]       fifo_data_o,
    output logic             bc_wr_o,
    output logic [7:0]       bc_data_o,
    output logic             irq_clr_o,
    output logic             launch_o,
    output logic [7:0]       launch_code_o,
    input  logic             xfer_done_i,
    input  logic [3:0]       xfer_result_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [3:0]       result_o
);
    localparam int BC_W = $clog2(PKT_MAX + 1);
    localparam logic [CNT_W-1:0] PKT_CNT = CNT_W'(PKT_MAX);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] ptr;
        logic [BC_W-1:0]  len;
        logic [BC_W-1:0]  idx;
        logic [7:0]       fb;
        logic             first;
        logic [3:0]       ep;
        logic [NAK_W-1:0] limit;
        logic [3:0]       res;
    } seq_t;

    seq_t s_d, s_q;

    logic            bank_clr, bank_load, bank_ack;
    logic [BC_W-1:0] load_bc;
    logic [7:0]      load_fb;
    logic [1:0]      avail;
    logic [BC_W-1:0] cur_bc;
    logic [7:0]      cur_fb;
    logic            nak_inc, nak_hit;
    logic            lat_clr, lat_pend;
    logic [3:0]      lat_res;

    uos_bank_track #(.BC_W(BC_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr_i(bank_clr), .load_i(bank_load),
        .load_bc_i(load_bc), .load_fb_i(load_fb), .ack_i(bank_ack),
        .avail_o(avail), .cur_bc_o(cur_bc), .cur_fb_o(cur_fb)
    );

    uos_nak_guard #(.NAK_W(NAK_W)) u_nak (
        .clk(clk), .rst_n(rst_n), .clr_i(bank_clr), .ack_i(bank_ack),
        .nak_i(nak_inc), .limit_i(s_q.limit), .hit_o(nak_hit)
    );

    uos_done_latch u_latch (
        .clk(clk), .rst_n(rst_n), .set_i(xfer_done_i), .res_i(xfer_result_i),
        .clr_i(lat_clr), .pend_o(lat_pend), .res_o(lat_res)
    );

    always_comb begin
        s_d         = s_q;
        fifo_wr_o   = 1'b0;
        fifo_data_o = 8'h00;
        bc_wr_o     = 1'b0;
        bc_data_o   = 8'h00;
        irq_clr_o   = 1'b0;
        launch_o    = 1'b0;
        done_o      = 1'b0;
        bank_clr    = 1'b0;
        bank_load   = 1'b0;
        bank_ack    = 1'b0;
        load_bc     = s_q.len;
        load_fb     = (s_q.idx == '0) ? src_data_i : s_q.fb;
        nak_inc     = 1'b0;
        lat_clr     = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.ep    = ep_i;
                    s_d.limit = nak_limit_i;
                    s_d.rem   = total_len_i;
                    s_d.ptr   = '0;
                    s_d.first = 1'b1;
                    s_d.res   = HS_ACK;
                    bank_clr  = 1'b1;
                    lat_clr   = 1'b1;
                    s_d.st    = (total_len_i == '0) ? ST_DONE : ST_PLAN;
                end
            end
            ST_PLAN: begin
                if (s_q.rem != '0 && avail != 2'd0) begin
                    s_d.len = (s_q.rem >= PKT_CNT) ? BC_W'(PKT_MAX) : BC_W'(s_q.rem);
                    s_d.rem = s_q.rem - ((s_q.rem >= PKT_CNT) ? PKT_CNT : s_q.rem);
                    s_d.idx = '0;
                    s_d.st  = ST_LOAD;
                end else begin
                    s_d.st  = ST_WAIT;
                end
            end
            ST_LOAD: begin
                fifo_wr_o   = 1'b1;
                fifo_data_o = src_data_i;
                s_d.ptr     = s_q.ptr + CNT_W'(1);
                s_d.idx     = s_q.idx + BC_W'(1);
                if (s_q.idx == '0) s_d.fb = src_data_i;
                if (s_q.idx == s_q.len - BC_W'(1)) begin
                    bank_load = 1'b1;
                    s_d.first = 1'b0;
                    s_d.st    = s_q.first ? ST_KICK_BC : ST_PLAN;
                end
            end
            ST_KICK_BC: begin
                bc_wr_o   = 1'b1;
                bc_data_o = 8'(cur_bc);
                s_d.st    = ST_KICK_GO;
            end
            ST_KICK_GO: begin
                irq_clr_o = 1'b1;
                launch_o  = 1'b1;
                lat_clr   = 1'b1;
                s_d.st    = ST_PLAN;
            end
            ST_WAIT: begin
                if (lat_pend) begin
                    lat_clr = 1'b1;
                    if (lat_res == HS_ACK) begin
                        bank_ack = 1'b1;
                        if (avail == 2'd1) begin
                            s_d.res = HS_ACK;
                            s_d.st  = ST_DONE;
                        end else begin
                            s_d.st  = ST_KICK_BC;
                        end
                    end else if (lat_res == HS_NAK) begin
                        nak_inc = 1'b1;
                        if (nak_hit) begin
                            s_d.res = HS_NAK;
                            s_d.st  = ST_DONE;
                        end else begin
                            s_d.st  = ST_RETRY_ZERO;
                        end
                    end else begin
                        s_d.res = lat_res;
                        s_d.st  = ST_DONE;
                    end
                end
            end
            ST_RETRY_ZERO: begin
                bc_wr_o   = 1'b1;
                bc_data_o = 8'h00;
                s_d.st    = ST_RETRY_FB;
            end
            ST_RETRY_FB: begin
                fifo_wr_o   = 1'b1;
                fifo_data_o = cur_fb;
                s_d.st      = ST_KICK_BC;
            end
            ST_DONE: begin
                done_o = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign src_addr_o    = s_q.ptr;
    assign launch_code_o = {TOKEN_OUT, s_q.ep};
    assign busy_o        = (s_q.st != ST_IDLE);
    assign result_o      = s_q.res;

    // R12: nothing is strobed while idle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(fifo_wr_o || bc_wr_o || irq_clr_o || launch_o));
    // R9: empty record completes on the next cycle with success
    a_r9_empty_record: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && total_len_i == '0) |=> (done_o && result_o == HS_ACK));
    // R4: a zero byte count flip is followed by the saved first byte
    a_r4_flip_then_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_wr_o && bc_data_o == 8'h00) |=> (fifo_wr_o && fifo_data_o == cur_fb));
    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: a start while busy does not end the operation
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);

endmodule

// File: tb/usb_out_seq_bench.sv
module usb_out_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  ep_i = '0;
    logic [15:0] total_len_i = '0;
    logic [15:0] nak_limit_i = '0;
    logic [15:0] src_addr_o;
    logic [7:0]  src_data_i;
    logic        fifo_wr_o, bc_wr_o, irq_clr_o, launch_o, busy_o, done_o;
    logic [7:0]  fifo_data_o, bc_data_o, launch_code_o;
    logic        xfer_done_i = 1'b0;
    logic [3:0]  xfer_result_i = '0;
    logic [3:0]  result_o;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_at(int a);
        return 8'((a * 37 + 11) ^ (a >> 8));
    endfunction

    assign src_data_i = mem_at(int'(src_addr_o));

    usb_out_seq u_usb_out_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ep_i(ep_i),
        .total_len_i(total_len_i), .nak_limit_i(nak_limit_i),
        .src_addr_o(src_addr_o), .src_data_i(src_data_i),
        .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o),
        .bc_wr_o(bc_wr_o), .bc_data_o(bc_data_o), .irq_clr_o(irq_clr_o),
        .launch_o(launch_o), .launch_code_o(launch_code_o),
        .xfer_done_i(xfer_done_i), .xfer_result_i(xfer_result_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    // expected strobe stream: kind 1 fifo, 2 byte count, 3 flag clear, 4 launch
    int          exp_kind[$];
    int          exp_val[$];
    string       exp_req[$];
    logic [3:0]  script_q[$];
    int          cur_delay = 0;
    int          done_cnt = 0;
    logic [3:0]  got_res = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int k, input int v, input string r);
        exp_kind.push_back(k);
        exp_val.push_back(v);
        exp_req.push_back(r);
    endtask

    task automatic expect_ev(input int k, input int v);
        if (exp_kind.size() == 0) begin
            check(1'b0, "R3", "unexpected strobe kind", k, 0);
        end else begin
            int ek = exp_kind.pop_front();
            int ev = exp_val.pop_front();
            string er = exp_req.pop_front();
            check(ek == k && ev == v, er, $sformatf("strobe kind %0d value", k),
                  k * 256 + v, ek * 256 + ev);
        end
    endtask

    // behavioural model of the record transfer, driven by the result script
    task automatic build_model(input int total, input logic [3:0] ep,
                               input int limit, output logic [3:0] res);
        logic [3:0] sq[$];
        int rem, avail, ptr, nak, loads;
        int cbc, cfb, pbc, pfb;
        bit first, fin;
        logic [3:0] r;
        sq = script_q;
        exp_kind.delete(); exp_val.delete(); exp_req.delete();
        res = 4'h0;
        rem = total; avail = 2; ptr = 0; nak = 0; loads = 0;
        cbc = 0; cfb = 0; pbc = 0; pfb = 0;
        first = 1'b1; fin = (total == 0);
        while (!fin) begin
            while (rem != 0 && avail != 0) begin
                int len = (rem >= 64) ? 64 : rem;
                for (int i = 0; i < len; i++)
                    push(1, int'(mem_at(ptr + i)), (loads == 0) ? "R1" : "R3");
                avail--;
                if (avail == 1) begin cbc = len; cfb = int'(mem_at(ptr)); end
                else            begin pbc = len; pfb = int'(mem_at(ptr)); end
                ptr += len; rem -= len; loads++;
                if (first) begin
                    first = 1'b0;
                    push(2, cbc, "R2"); push(3, 0, "R2"); push(4, 16 + int'(ep), "R2");
                end
            end
            r = (sq.size() != 0) ? sq.pop_front() : 4'h0;
            if (r == 4'h4) begin
                nak++;
                if (nak == limit) begin res = 4'h4; fin = 1'b1; end
                else begin
                    push(2, 0, "R4"); push(1, cfb, "R4"); push(2, cbc, "R4");
                    push(3, 0, "R4"); push(4, 16 + int'(ep), "R4");
                end
            end else if (r == 4'h0) begin
                avail++; nak = 0;
                if (avail != 2) begin
                    cbc = pbc; cfb = pfb;
                    push(2, cbc, "R6"); push(3, 0, "R6"); push(4, 16 + int'(ep), "R6");
                end else fin = 1'b1;
            end else begin
                res = r; fin = 1'b1;
            end
        end
    endtask

    // peripheral: answers each launch after cur_delay cycles
    bit resp_armed = 1'b0;
    int resp_wait = 0;
    logic [3:0] resp_code = '0;
    always @(negedge clk) begin
        xfer_done_i = 1'b0;
        if (resp_armed) begin
            if (resp_wait == 0) begin
                xfer_done_i = 1'b1;
                xfer_result_i = resp_code;
                resp_armed = 1'b0;
            end else resp_wait--;
        end
        if (rst_n && launch_o) begin
            resp_armed = 1'b1;
            resp_wait = cur_delay;
            resp_code = (script_q.size() != 0) ? script_q.pop_front() : 4'h0;
        end
    end

    // per-clock comparison of every strobe against the model stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr_o) expect_ev(1, int'(fifo_data_o));
            if (bc_wr_o)   expect_ev(2, int'(bc_data_o));
            if (irq_clr_o) expect_ev(3, 0);
            if (launch_o)  expect_ev(4, int'(launch_code_o));
            if (done_o) begin done_cnt++; got_res = result_o; end
        end
    end

    task automatic run_case(input string tag, input int total, input logic [3:0] ep,
                            input int limit, input int delay, input bit poke);
        logic [3:0] exp_res;
        int waited;
        build_model(total, ep, limit, exp_res);
        cur_delay = delay;
        done_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; ep_i = ep; total_len_i = 16'(total); nak_limit_i = 16'(limit);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1; total_len_i = 16'd7; ep_i = 4'h2;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        repeat (4) @(negedge clk);
        check(done_cnt == 1, poke ? "R10" : "R8", {tag, " done pulses"}, done_cnt, 1);
        check(got_res == exp_res, tag, "final result", got_res, exp_res);
        check(exp_kind.size() == 0, tag, "strobes left unissued", exp_kind.size(), 0);
        check(!busy_o, tag, "busy after done", busy_o, 0);
        script_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!busy_o && !done_o, "R12", "busy/done after reset", {busy_o, done_o}, 0);
        check(!(fifo_wr_o || bc_wr_o || irq_clr_o || launch_o), "R12",
              "strobes during reset", {fifo_wr_o, bc_wr_o, irq_clr_o, launch_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !done_o, "R12", "idle after reset release", busy_o, 0);

        // R9: empty record, done one cycle after start
        @(negedge clk);
        start_i = 1'b1; total_len_i = '0; ep_i = 4'h3;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && result_o == 4'h0, "R9", "empty record done", {done_o, result_o}, 16);
        repeat (3) @(negedge clk);

        // R1 R2 R8: single short packet, all ACK
        run_case("R8", 40, 4'h5, 3, 3, 1'b0);
        // R3: two packets, second loaded while first is on the bus
        run_case("R3", 128, 4'h9, 3, 200, 1'b0);
        // R11 R6: completions arriving while loading, NAK count reset by ACK
        script_q = '{4'h4, 4'h4, 4'h0, 4'h4, 4'h4, 4'h0, 4'h0, 4'h4, 4'h0, 4'h0};
        run_case("R11", 300, 4'h7, 3, 0, 1'b0);
        // R4 R6: NAK retries with a long response delay
        script_q = '{4'h0, 4'h4, 4'h4, 4'h0, 4'h4, 4'h0};
        run_case("R6", 200, 4'hA, 5, 90, 1'b0);
        // R5: NAK limit reached
        script_q = '{4'h4, 4'h4, 4'h4};
        run_case("R5", 100, 4'h1, 3, 4, 1'b0);
        // R7: other handshake code ends at once
        script_q = '{4'h0, 4'hE};
        run_case("R7", 150, 4'hC, 3, 2, 1'b0);
        // R10: start while busy ignored
        run_case("R10", 70, 4'hF, 3, 6, 1'b1);
        // R4: exact single full packet with one NAK
        script_q = '{4'h4, 4'h0};
        run_case("R4", 64, 4'h0, 2, 1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule